// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Block

This block holds the inter-processor interrupt state for one core. Software on the core reaches it through a 32-bit register access port with an 8-bit byte offset. Through that port it can read the pending-interrupt word, program a mask word, post bits through a set register and remove them through a clear register. It can also use eight 32-bit mailbox words, which other cores use to pass arguments alongside an interrupt. The pending word can never be written directly. It changes only as a side effect of the set and clear registers and of incoming send requests.

The single interrupt line to the core is held by a two-state machine, `IRQ_LOW` and `IRQ_HIGH`. The `RAISE` transition (`IRQ_LOW` to `IRQ_HIGH`) happens on any event that sets bits, if the resulting pending word ANDed with the mask is nonzero. The `LOWER` transition (`IRQ_HIGH` to `IRQ_LOW`) happens only on a clear-register write that leaves the pending word entirely zero while the mask is nonzero. No other event moves the machine. This asymmetry is deliberate: masking alone never drops the line.

A send-request word written to the send offset names a target core and a vector. If the target is this core, the vector bit is posted locally. If the target is another existing core, the request is forwarded for one cycle on the forward outputs. If the target does not exist, the request is rejected with an error. Requests already routed from other cores arrive on the incoming send port.

Top module: `ipi_core_regs`

## Requirements
- R1: After reset the pending word, the mask word, every mailbox word and the interrupt line are all zero.
- R2: Address decoding works on word offsets: pending 0x00, mask 0x04, set 0x08, clear 0x0C, mailbox 0x20–0x3C, send 0x40. A read of set, clear, send, any other offset, or any offset whose bits 1:0 are nonzero returns zero. Such a write changes nothing and raises no error.
- R3: A write to the pending offset 0x00 leaves the pending word unchanged and drives `acc_err` high in that same cycle.
- R4: A set-register write ORs the write data into the pending word. If the line is low and the new pending word ANDed with the mask is nonzero, the line is high from the next clock edge.
- R5: A clear-register write clears every pending bit that is 1 in the write data. The line falls at the next edge only if the resulting pending word is zero and the mask is nonzero. Otherwise it keeps its level.
- R6: Writing the mask word never changes the line. A set event whose result is entirely masked leaves the line low.
- R7: The eight mailbox words at 0x20 + 4·i (i = 0..7) store their write data and read it back independently.
- R8: A one-cycle pulse on `snd_valid` with vector v (0..31) acts as a set-register write of the single bit 1<<v, including the R4 raise rule.
- R9: A write to 0x40 carries a target core in bits 25:16 and a vector in bits 4:0. For a target equal to `CORE_ID`, bit 1<<vector is posted locally. For any other target below `NUM_CORES`, `fwd_valid` is high for the next cycle with that target and vector. For a target of `NUM_CORES` or above, `acc_err` is high in the write cycle and no state changes and nothing is forwarded.
- R10: When a clear write and an incoming send land in the same cycle, the clear applies first and the sent bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the access cycle |
| acc_err | output | 1 | Access error in the access cycle |
| snd_valid | input | 1 | Incoming routed send request |
| snd_vec | input | 5 | Vector of the incoming send request |
| ipi_irq | output | 1 | Interrupt line to the core |
| fwd_valid | output | 1 | Outgoing send request for another core |
| fwd_target | output | 10 | Target core of the outgoing request |
| fwd_vec | output | 5 | Vector of the outgoing request |

## Verification
The raise and lower rules are exercised with set and clear data of three kinds: fully masked data, which separates "pending nonzero" from "pending and mask nonzero"; partial clears, which separate "some bit cleared" from "all cleared"; and clears issued while the mask is zero, which show that the line only falls with a nonzero mask. Send words use targets equal to the own core, to another core and beyond the core count, and these three outcomes must differ at the ports. A clear that coincides with an incoming send fixes the order in which the two are applied. Random mixes of all offsets, including misaligned ones, then compare every read, error and line level against a bench model.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int REG_W  = 32;
    localparam int VEC_W  = 5;
    localparam int TGT_W  = 10;
    localparam int TGT_LSB = 16;
    localparam int WOFF_W = 6;

    localparam logic [WOFF_W-1:0] WOFF_PEND = 6'd0;
    localparam logic [WOFF_W-1:0] WOFF_MASK = 6'd1;
    localparam logic [WOFF_W-1:0] WOFF_SET  = 6'd2;
    localparam logic [WOFF_W-1:0] WOFF_CLR  = 6'd3;
    localparam logic [WOFF_W-1:0] WOFF_MBX0 = 6'd8;
    localparam logic [WOFF_W-1:0] WOFF_SEND = 6'd16;

    typedef enum logic [0:0] {
        IRQ_LOW  = 1'b0,
        IRQ_HIGH = 1'b1
    } irq_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_MASK,
        SEL_SET,
        SEL_CLR,
        SEL_MBX,
        SEL_SEND
    } reg_sel_e;

    function automatic logic [REG_W-1:0] vec_bit(input logic [VEC_W-1:0] v);
        return REG_W'(1) << v;
    endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int MBX_WORDS = 8,
    localparam int IDX_W = (MBX_WORDS > 1) ? $clog2(MBX_WORDS) : 1
) (
    input  logic [7:0]       addr,
    output reg_sel_e         sel,
    output logic [IDX_W-1:0] mbx_idx
);
    logic [WOFF_W-1:0] woff;
    logic              aligned;

    always_comb begin
        woff    = addr[7:2];
        aligned = (addr[1:0] == 2'b00);
        sel     = SEL_NONE;
        mbx_idx = '0;
        if (aligned) begin
            if (woff == WOFF_PEND) begin
                sel = SEL_PEND;
            end else if (woff == WOFF_MASK) begin
                sel = SEL_MASK;
            end else if (woff == WOFF_SET) begin
                sel = SEL_SET;
            end else if (woff == WOFF_CLR) begin
                sel = SEL_CLR;
            end else if (woff == WOFF_SEND) begin
                sel = SEL_SEND;
            end else if ((32'(woff) >= 32'(WOFF_MBX0)) &&
                         (32'(woff) <  32'(WOFF_MBX0) + 32'(MBX_WORDS))) begin
                sel     = SEL_MBX;
                mbx_idx = IDX_W'(woff - WOFF_MBX0);
            end
        end
    end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
    import ipi_pkg::*;
#(
    parameter int WORDS = 8,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);
    logic [REG_W-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (wr_en && (idx == IDX_W'(g))) begin
                words[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (idx == IDX_W'(i)) begin
                rd_data = words[i];
            end
        end
    end
endmodule

// File: rtl/ipi_send_decode.sv
module ipi_send_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CORE_ID   = 0
) (
    input  logic [TGT_W-1:0] tgt,
    output logic             tgt_ok,
    output logic             tgt_self
);
    always_comb begin
        tgt_ok   = (32'(tgt) < 32'(NUM_CORES));
        tgt_self = tgt_ok && (tgt == TGT_W'(CORE_ID));
    end
endmodule

// File: rtl/ipi_irq_fsm.sv
module ipi_irq_fsm
    import ipi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_evt,
    input  logic             clr_evt,
    input  logic [REG_W-1:0] pend_next,
    input  logic [REG_W-1:0] mask_q,
    output logic             irq
);
    irq_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= IRQ_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_LOW: begin
                // RAISE
                if (set_evt && ((pend_next & mask_q) != '0)) begin
                    st_d = IRQ_HIGH;
                end
            end
            IRQ_HIGH: begin
                // LOWER
                if (clr_evt && (pend_next == '0) && (mask_q != '0)) begin
                    st_d = IRQ_LOW;
                end
            end
        endcase
    end

    always_comb begin
        irq = (st_q == IRQ_HIGH);
    end
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CORE_ID   = 0,
    parameter int MBX_WORDS = 8,
    localparam int IDX_W = (MBX_WORDS > 1) ? $clog2(MBX_WORDS) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [7:0]  acc_addr,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    output logic        acc_err,
    input  logic        snd_valid,
    input  logic [4:0]  snd_vec,
    output logic        ipi_irq,
    output logic        fwd_valid,
    output logic [9:0]  fwd_target,
    output logic [4:0]  fwd_vec
);
    reg_sel_e         sel;
    logic [IDX_W-1:0] mbx_idx;
    logic [REG_W-1:0] mbx_rd;
    logic [REG_W-1:0] pend_q, pend_next, mask_q;
    logic [REG_W-1:0] set_bits, clr_bits;
    logic             wr, set_wr, clr_wr, mask_wr, mbx_wr, send_wr;
    logic             tgt_ok, tgt_self, self_send, out_send, set_evt;
    logic             fwd_valid_q;
    logic [TGT_W-1:0] fwd_tgt_q;
    logic [VEC_W-1:0] fwd_vec_q;

    ipi_decode #(.MBX_WORDS(MBX_WORDS)) u_dec (
        .addr    (acc_addr),
        .sel     (sel),
        .mbx_idx (mbx_idx)
    );

    ipi_send_decode #(.NUM_CORES(NUM_CORES), .CORE_ID(CORE_ID)) u_snd (
        .tgt      (acc_wdata[TGT_LSB +: TGT_W]),
        .tgt_ok   (tgt_ok),
        .tgt_self (tgt_self)
    );

    always_comb begin
        wr        = acc_valid && acc_write;
        set_wr    = wr && (sel == SEL_SET);
        clr_wr    = wr && (sel == SEL_CLR);
        mask_wr   = wr && (sel == SEL_MASK);
        mbx_wr    = wr && (sel == SEL_MBX);
        send_wr   = wr && (sel == SEL_SEND);
        self_send = send_wr && tgt_self;
        out_send  = send_wr && tgt_ok && !tgt_self;
        acc_err   = (wr && (sel == SEL_PEND)) || (send_wr && !tgt_ok);

        set_bits = '0;
        if (set_wr)    set_bits = set_bits | acc_wdata;
        if (self_send) set_bits = set_bits | vec_bit(acc_wdata[VEC_W-1:0]);
        if (snd_valid) set_bits = set_bits | vec_bit(snd_vec);
        clr_bits  = clr_wr ? acc_wdata : '0;
        pend_next = (pend_q & ~clr_bits) | set_bits;
        set_evt   = set_wr || self_send || snd_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= '0;
            mask_q      <= '0;
            fwd_valid_q <= 1'b0;
            fwd_tgt_q   <= '0;
            fwd_vec_q   <= '0;
        end else begin
            pend_q      <= pend_next;
            fwd_valid_q <= out_send;
            if (mask_wr) begin
                mask_q <= acc_wdata;
            end
            if (out_send) begin
                fwd_tgt_q <= acc_wdata[TGT_LSB +: TGT_W];
                fwd_vec_q <= acc_wdata[VEC_W-1:0];
            end
        end
    end

    ipi_mailbox #(.WORDS(MBX_WORDS)) u_mbx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mbx_wr),
        .idx     (mbx_idx),
        .wr_data (acc_wdata),
        .rd_data (mbx_rd)
    );

    ipi_irq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_evt   (set_evt),
        .clr_evt   (clr_wr),
        .pend_next (pend_next),
        .mask_q    (mask_q),
        .irq       (ipi_irq)
    );

    always_comb begin
        unique case (sel)
            SEL_PEND: acc_rdata = pend_q;
            SEL_MASK: acc_rdata = mask_q;
            SEL_MBX:  acc_rdata = mbx_rd;
            default:  acc_rdata = '0;
        endcase
    end

    assign fwd_valid  = fwd_valid_q;
    assign fwd_target = fwd_tgt_q;
    assign fwd_vec    = fwd_vec_q;
endmodule

// File: rtl/ipi_core_regs_chk.sv
module ipi_core_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [7:0]  acc_addr,
    input logic [31:0] acc_rdata,
    input logic        acc_err,
    input logic        snd_valid,
    input logic        ipi_irq,
    input logic        fwd_valid,
    input logic [31:0] pend
);
    logic wr_any, rd_any;
    assign wr_any = acc_valid && acc_write && (acc_addr[1:0] == 2'b00);
    assign rd_any = acc_valid && !acc_write;

    AST_RAISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ipi_irq) |-> $past(snd_valid || (wr_any && (acc_addr[7:2] == 6'd2 || acc_addr[7:2] == 6'd16)))); // R4
    AST_LOWER_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ipi_irq) |-> $past(wr_any && acc_addr[7:2] == 6'd3)); // R5
    AST_PEND_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && acc_addr[7:2] == 6'd0) |-> acc_err); // R3
    AST_PEND_HOLD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err && !snd_valid) |=> $stable(pend)); // R3
    AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && (acc_addr[7:2] == 6'd2 || acc_addr[7:2] == 6'd3)) |-> acc_rdata == 32'd0); // R2
    AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && acc_addr[1:0] != 2'b00) |-> acc_rdata == 32'd0); // R2
    AST_FWD_FROM_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(wr_any && acc_addr[7:2] == 6'd16 && !acc_err)); // R9
endmodule

bind ipi_core_regs ipi_core_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_rdata (acc_rdata),
    .acc_err   (acc_err),
    .snd_valid (snd_valid),
    .ipi_irq   (ipi_irq),
    .fwd_valid (fwd_valid),
    .pend      (pend_q)
);

// File: tb/ipi_core_regs_tb_top.sv
module ipi_core_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NC  = 4;
    localparam int MYID = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_err;
    logic        snd_valid = 1'b0;
    logic [4:0]  snd_vec = '0;
    logic        ipi_irq, fwd_valid;
    logic [9:0]  fwd_target;
    logic [4:0]  fwd_vec;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_pend, m_mask;
    logic [31:0] m_mbx [8];
    bit          m_irq, m_fv;
    logic [9:0]  m_ft;
    logic [4:0]  m_fvec;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_core_regs #(.NUM_CORES(NC), .CORE_ID(MYID), .MBX_WORDS(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_err(acc_err), .snd_valid(snd_valid), .snd_vec(snd_vec),
        .ipi_irq(ipi_irq), .fwd_valid(fwd_valid), .fwd_target(fwd_target),
        .fwd_vec(fwd_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [5:0] w = a[7:2];
        if (a[1:0] != 2'b00) return 32'd0;
        if (w == 6'd0) return m_pend;
        if (w == 6'd1) return m_mask;
        if (w >= 6'd8 && w <= 6'd15) return m_mbx[w - 6'd8];
        return 32'd0;
    endfunction

    // one access cycle; called at a falling edge
    task automatic step(input bit v, input bit w, input logic [7:0] a, input logic [31:0] d,
                        input bit sv, input logic [4:0] svec, input string req);
        logic [5:0]  wo;
        bit          wr, al, e_err, set_ev, clr_ev;
        logic [31:0] setb, clrb, nxt, old_mask;
        logic [9:0]  tgt;
        acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d;
        snd_valid = sv; snd_vec = svec;
        #1;
        wo = a[7:2]; al = (a[1:0] == 2'b00); wr = v && w && al;
        tgt = d[25:16];
        e_err = wr && ((wo == 6'd0) || (wo == 6'd16 && int'(tgt) >= NC));
        chk(req, {31'd0, acc_err}, {31'd0, e_err});
        if (v && !w) chk(req, acc_rdata, exp_read(a));
        setb = '0; clrb = '0; set_ev = 0; clr_ev = 0; old_mask = m_mask; m_fv = 0;
        if (wr) begin
            if (wo == 6'd1) m_mask = d;
            if (wo == 6'd2) begin setb = d; set_ev = 1; end
            if (wo == 6'd3) begin clrb = d; clr_ev = 1; end
            if (wo >= 6'd8 && wo <= 6'd15) m_mbx[wo - 6'd8] = d;
            if (wo == 6'd16 && int'(tgt) < NC) begin
                if (int'(tgt) == MYID) begin setb |= 32'd1 << d[4:0]; set_ev = 1; end
                else begin m_fv = 1; m_ft = tgt; m_fvec = d[4:0]; end
            end
        end
        if (sv) begin setb |= 32'd1 << svec; set_ev = 1; end
        nxt = (m_pend & ~clrb) | setb;
        if (!m_irq && set_ev && (nxt & old_mask) != 0) m_irq = 1;
        else if (m_irq && clr_ev && nxt == 0 && old_mask != 0) m_irq = 0;
        m_pend = nxt;
        @(posedge clk); #1;
        acc_valid = 0; snd_valid = 0;
        chk(req, {31'd0, ipi_irq}, {31'd0, m_irq});
        chk(req, {31'd0, fwd_valid}, {31'd0, m_fv});
        if (m_fv) chk(req, {17'd0, fwd_vec, fwd_target}, {17'd0, m_fvec, m_ft});
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        step(1, 0, a, 32'd0, 0, 5'd0, req);
    endtask
    task automatic wrt(input logic [7:0] a, input logic [31:0] d, input string req);
        step(1, 1, a, d, 0, 5'd0, req);
    endtask
    function automatic logic [31:0] send_word(input int t, input int v);
        return (32'(t) << 16) | 32'(v);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_pend = 0; m_mask = 0; m_irq = 0; m_fv = 0; m_ft = 0; m_fvec = 0;
        for (int i = 0; i < 8; i++) m_mbx[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1", {31'd0, ipi_irq}, 32'd0);
        rd(8'h00, "R1"); rd(8'h04, "R1");
        for (int i = 0; i < 8; i++) rd(8'(8'h20 + 4 * i), "R1");
        // R3 pending word write is rejected
        wrt(8'h00, 32'hFFFF_FFFF, "R3"); rd(8'h00, "R3");
        // R6 masked set leaves line low; mask write does not raise
        wrt(8'h08, 32'h0000_00F0, "R6"); rd(8'h00, "R6");
        wrt(8'h04, 32'h0000_0010, "R6");
        // R4 set with zero data raises because masked pending is now nonzero
        wrt(8'h08, 32'h0, "R4");
        // R6 mask write to zero does not drop the line
        wrt(8'h04, 32'h0, "R6");
        // R5 clear with mask zero: all clear but line stays
        wrt(8'h0C, 32'hFFFF_FFFF, "R5"); rd(8'h00, "R5");
        wrt(8'h04, 32'h1, "R5"); wrt(8'h08, 32'h3, "R4");
        wrt(8'h0C, 32'h1, "R5");   // partial clear, line stays
        wrt(8'h0C, 32'h2, "R5");   // last bit gone, line falls
        // R7 mailbox
        for (int i = 0; i < 8; i++) wrt(8'(8'h20 + 4 * i), 32'hA5A5_0000 + 32'(i * 7), "R7");
        for (int i = 0; i < 8; i++) rd(8'(8'h20 + 4 * i), "R7");
        // R2 zero reads and ignored writes
        rd(8'h08, "R2"); rd(8'h0C, "R2"); rd(8'h40, "R2"); rd(8'h10, "R2"); rd(8'hFC, "R2");
        rd(8'h21, "R2"); wrt(8'h22, 32'hDEAD_BEEF, "R2"); rd(8'h20, "R2");
        wrt(8'h01, 32'h1234, "R2"); rd(8'h00, "R2");
        // R8 incoming send of vector 31
        wrt(8'h04, 32'h8000_0000, "R8");
        step(0, 0, 8'h0, 32'h0, 1, 5'd31, "R8"); rd(8'h00, "R8");
        wrt(8'h0C, 32'h8000_0000, "R8");
        // R9 send words: self, other, nonexistent
        step(1, 1, 8'h40, send_word(MYID, 31), 0, 5'd0, "R9"); rd(8'h00, "R9");
        step(1, 1, 8'h40, send_word(3, 9), 0, 5'd0, "R9");
        step(1, 1, 8'h40, send_word(NC, 4), 0, 5'd0, "R9");
        step(1, 1, 8'h40, send_word(1023, 4), 0, 5'd0, "R9"); rd(8'h00, "R9");
        // R10 clear and incoming send together
        step(1, 1, 8'h0C, 32'hFFFF_FFFF, 1, 5'd31, "R10"); rd(8'h00, "R10");
        wrt(8'h0C, 32'hFFFF_FFFF, "R5");
        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int k = int'($urandom_range(0, 9));
            logic [7:0] a;
            logic [31:0] d = $urandom();
            bit sv = ($urandom_range(0, 5) == 0);
            string req;
            unique case (k)
                0: begin a = 8'h00; req = "R3"; end
                1: begin a = 8'h04; req = "R6"; d = d & {32{$urandom_range(0, 3) != 0}}; end
                2: begin a = 8'h08; req = "R4"; d = d & 32'h0000_0F0F; end
                3, 4: begin a = 8'h0C; req = "R5"; if ($urandom_range(0, 1) == 1) d = 32'hFFFF_FFFF; end
                5: begin a = 8'(8'h20 + 4 * $urandom_range(0, 7)); req = "R7"; end
                6: begin a = 8'h40; req = "R9"; d = send_word(int'($urandom_range(0, 5)), int'($urandom_range(0, 31))); end
                7: begin a = 8'($urandom()); req = "R2"; end
                default: begin a = 8'(4 * $urandom_range(0, 17)); req = "R8"; end
            endcase
            step(1, bit'($urandom_range(0, 1)), a, d, sv, 5'($urandom()), req);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule